// File: doc/BRIEF.md
# Next-Fetch-Address Unit with Target Buffer and Return Stack

This block picks the address that the front end fetches in the next cycle. It looks up the current fetch PC in a direct-mapped branch target buffer. Each entry holds a tag, a target, a valid bit and a 2-bit instruction kind. The unit also takes a predicted-direction bit from an external direction predictor. When the lookup hits and the predictor says taken, the unit redirects. Otherwise it falls through to PC + 4.

The entry's kind tells the unit that the instruction is a call or a return before that instruction is decoded. A taken call pushes its fall-through address onto a small circular return stack. A taken return ignores the stored target and uses the top of the stack, which it pops. When the stack is empty, a return falls back to PC + 4.

Entries are written through a resolution port when branches resolve. A flush input empties the stack.

Top module: `fetch_target_unit`

## Requirements
- R1: After reset every buffer entry is invalid, so every lookup misses and `next_pc` equals `fetch_pc + 4`.
- R2: A lookup hits only when the entry selected by `fetch_pc[7:2]` is valid and its stored tag equals `fetch_pc[31:8]`. A PC with the same index but another tag misses and gives `fetch_pc + 4`.
- R3: On a hit whose kind is not return, `next_pc` is the stored target when `pred_taken` is 1 and `fetch_pc + 4` when `pred_taken` is 0.
- R4: The kind encoding is 00 conditional, 01 jump, 10 call, 11 return. A taken hit on a call entry with `fetch_vld` high pushes `fetch_pc + 4` onto the stack.
- R5: A taken hit on a return entry with `fetch_vld` high and a non-empty stack gives the top-of-stack value as `next_pc` and pops it, so returns come back in last-in-first-out order.
- R6: A taken hit on a return entry with an empty stack gives `fetch_pc + 4` and leaves the stack empty.
- R7: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry. After 9 pushes, 8 returns yield the newest 8 addresses and the next return sees an empty stack.
- R8: `flush` empties the stack in the next cycle and takes priority over a push or pop in the same cycle.
- R9: With `fetch_vld` low, `next_pc` is still computed, but the stack is neither pushed nor popped.
- R10: A write on the update port (`upd_en` high) makes the entry at `upd_pc[7:2]` valid from the next cycle, with the tag, target and kind given. A write to an occupied index replaces the old contents.
- R11: A return entry looked up with `pred_taken` at 0 gives `fetch_pc + 4` and does not pop the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Lookup is a real fetch, so stack updates are allowed |
| fetch_pc | input | 32 | Current fetch address |
| pred_taken | input | 1 | External direction prediction |
| flush | input | 1 | Empties the return stack |
| upd_en | input | 1 | Buffer write enable |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target |
| upd_kind | input | 2 | Kind of the resolved branch (00 cond, 01 jump, 10 call, 11 return) |
| next_pc | output | 32 | Predicted next fetch address |

## Verification
The bench builds the unit with its default parameters: a 64-entry buffer indexed by `fetch_pc[7:2]` and a stack 8 deep. The shallow stack means nine calls in a row wrap the pointer and overwrite the oldest entry. The bench then unwinds that whole sequence and one return beyond it, so the empty-stack fall-back is reached. The small index field lets the bench pick two addresses with the same index and different tags, which checks that tag compare rejects the aliased address.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
    localparam int unsigned XLEN = 32;

    typedef enum logic [1:0] {
        BR_COND = 2'b00,
        BR_JUMP = 2'b01,
        BR_CALL = 2'b10,
        BR_RET  = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic            hit;
        br_kind_e        kind;
        logic [XLEN-1:0] target;
    } lookup_t;

    function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
        return pc + XLEN'(4);
    endfunction
endpackage

// File: rtl/ftu_btb.sv
module ftu_btb
    import ftu_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] rd_pc,
    output lookup_t         rd_o,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [XLEN-1:0] wr_target,
    input  br_kind_e        wr_kind
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_LO  = IDX_W + 2;
    localparam int unsigned TAG_W   = XLEN - TAG_LO;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [XLEN-1:0]    tgt_q [ENTRIES];
    br_kind_e           kind_q[ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    assign rd_idx = rd_pc[TAG_LO-1:2];
    assign wr_idx = wr_pc[TAG_LO-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_pc[XLEN-1:TAG_LO];
            tgt_q[wr_idx]  <= wr_target;
            kind_q[wr_idx] <= wr_kind;
        end
    end

    always_comb begin
        rd_o.hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_pc[XLEN-1:TAG_LO]);
        rd_o.kind   = kind_q[rd_idx];
        rd_o.target = tgt_q[rd_idx];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld_q == '0));

    // R10
    write_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/ftu_ras.sv
module ftu_ras
    import ftu_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush_i,
    input  logic            push_i,
    input  logic [XLEN-1:0] push_data_i,
    input  logic            pop_i,
    output logic            top_vld_o,
    output logic [XLEN-1:0] top_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [XLEN-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, top_idx;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    assign top_idx   = ptr_dec(wptr_q);
    assign top_vld_o = (cnt_q != '0);
    assign top_o     = mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (push_i) begin
            wptr_q <= ptr_inc(wptr_q);
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && top_vld_o) begin
            wptr_q <= top_idx;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush_i && push_i) mem_q[wptr_q] <= push_data_i;
    end

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !top_vld_o);

    // R4
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && !flush_i) |=> (top_vld_o && top_o == $past(push_data_i)));

    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> top_vld_o);
endmodule

// File: rtl/fetch_target_unit.sv
module fetch_target_unit
    import ftu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_vld,
    input  logic [31:0] fetch_pc,
    input  logic        pred_taken,
    input  logic        flush,
    input  logic        upd_en,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target,
    input  logic [1:0]  upd_kind,
    output logic [31:0] next_pc
);
    localparam int unsigned BTB_IDX_W = 6;
    localparam int unsigned RAS_DEPTH = 8;

    lookup_t         lk;
    logic            use_btb, is_call, is_ret;
    logic            push, pop, tos_vld;
    logic [XLEN-1:0] seq_pc, tos;

    ftu_btb #(.IDX_W(BTB_IDX_W)) btb_i (
        .clk       (clk),
        .rst       (rst),
        .rd_pc     (fetch_pc),
        .rd_o      (lk),
        .wr_en     (upd_en),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .wr_kind   (br_kind_e'(upd_kind))
    );

    assign seq_pc  = seq_addr(fetch_pc);
    assign use_btb = lk.hit && pred_taken;
    assign is_call = use_btb && (lk.kind == BR_CALL);
    assign is_ret  = use_btb && (lk.kind == BR_RET);
    assign push    = fetch_vld && is_call;
    assign pop     = fetch_vld && is_ret && tos_vld;

    ftu_ras #(.DEPTH(RAS_DEPTH)) ras_i (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush),
        .push_i      (push),
        .push_data_i (seq_pc),
        .pop_i       (pop),
        .top_vld_o   (tos_vld),
        .top_o       (tos)
    );

    always_comb begin
        next_pc = seq_pc;
        if (use_btb) begin
            if (lk.kind == BR_RET) next_pc = tos_vld ? tos : seq_pc;
            else                   next_pc = lk.target;
        end
    end

    // R9
    idle_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |-> !(push || pop));
endmodule

// File: tb/fetch_target_unit_tb_top.sv
module fetch_target_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken = 1'b0;
    logic        flush = 1'b0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic [1:0]  upd_kind = '0;
    logic [31:0] next_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] pc;
        string       req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    fetch_target_unit dut_i (
        .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .flush(flush), .upd_en(upd_en),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_kind(upd_kind),
        .next_pc(next_pc)
    );

    // monitor: compares mid-cycle, after the driver set inputs at posedge+1
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (next_pc !== it.exp) begin
                n_bad++;
                $display("FAIL %s pc=%h next_pc actual=%h expected=%h",
                         it.req, it.pc, next_pc, it.exp);
            end
        end
    end

    task automatic wr_entry(input logic [31:0] pc, input logic [31:0] tgt,
                            input logic [1:0] kind);
        upd_en = 1'b1; upd_pc = pc; upd_target = tgt; upd_kind = kind;
        @(posedge clk); #1;
        upd_en = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] pc, input logic tk, input logic vld,
                         input logic [31:0] exp, input string req);
        sb_item_t it;
        fetch_pc = pc; pred_taken = tk; fetch_vld = vld;
        it.exp = exp; it.pc = pc; it.req = req;
        sb_q.push_back(it);
        @(posedge clk); #1;
        fetch_vld = 1'b0; pred_taken = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    localparam logic [1:0] K_COND = 2'b00, K_JUMP = 2'b01, K_CALL = 2'b10, K_RET = 2'b11;
    localparam logic [31:0] RET_PC = 32'h0000_300C;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: empty buffer
        fetch(32'h104, 1'b1, 1'b1, 32'h108, "R1");
        fetch(32'h300C, 1'b1, 1'b1, 32'h3010, "R1");

        wr_entry(32'h104, 32'h800, K_COND);
        wr_entry(32'h110, 32'hA00, K_JUMP);
        wr_entry(32'h1008, 32'h2000, K_CALL);
        wr_entry(RET_PC, 32'hDEAD_0000, K_RET);
        // R3
        fetch(32'h104, 1'b1, 1'b1, 32'h800, "R3");
        fetch(32'h104, 1'b0, 1'b1, 32'h108, "R3");
        fetch(32'h110, 1'b1, 1'b1, 32'hA00, "R3");
        // R2: same index 1, other tag
        fetch(32'h204, 1'b1, 1'b1, 32'h208, "R2");
        // R6: return on empty stack
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R6");
        // R4 + R5
        fetch(32'h1008, 1'b1, 1'b1, 32'h2000, "R4");
        // R11: untaken return, no pop
        fetch(RET_PC, 1'b0, 1'b1, 32'h3010, "R11");
        fetch(RET_PC, 1'b1, 1'b1, 32'h100C, "R5");
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R6");
        // R9: idle call does not push
        fetch(32'h1008, 1'b1, 1'b0, 32'h2000, "R9");
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R9");
        // R7: nine calls at distinct addresses, then unwind
        for (int k = 0; k < 9; k++) wr_entry(32'h20 + 4*k, 32'h900, K_CALL);
        for (int k = 0; k < 9; k++) fetch(32'h20 + 4*k, 1'b1, 1'b1, 32'h900, "R7");
        for (int k = 8; k >= 1; k--) fetch(RET_PC, 1'b1, 1'b1, 32'h24 + 4*k, "R7");
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R7");
        // R8: flush empties stack
        fetch(32'h1008, 1'b1, 1'b1, 32'h2000, "R8");
        fetch(32'h20, 1'b1, 1'b1, 32'h900, "R8");
        do_flush();
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R8");
        // R8: flush beats a push in the same cycle
        flush = 1'b1;
        fetch(32'h1008, 1'b1, 1'b1, 32'h2000, "R8");
        flush = 1'b0;
        fetch(RET_PC, 1'b1, 1'b1, 32'h3010, "R8");
        // R10: overwrite entry at index 1 as a return
        fetch(32'h1008, 1'b1, 1'b1, 32'h2000, "R10");
        wr_entry(32'h104, 32'h5555_0000, K_RET);
        fetch(32'h104, 1'b1, 1'b1, 32'h100C, "R10");
        wr_entry(32'h204, 32'h0000_0C00, K_JUMP);
        fetch(32'h204, 1'b1, 1'b1, 32'hC00, "R10");
        fetch(32'h104, 1'b1, 1'b1, 32'h108, "R10");
        @(posedge clk); @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule